// File: doc/BRIEF.md
# Pixel Component Repacker

This block takes one pixel word from memory each cycle and turns it into a word for a parallel display bus. Each of the three colour components is cut out of the pixel word with its own top-bit position and its own 10-bit mask. The mask is aligned to the top of a 10-bit field. A narrow field can be widened by copying its top bits into the empty low bits. The three 10-bit components travel on a 30-bit internal bus, with red in the top slot. A second set of per-component positions and masks then places them on the output pins.

A 2-bit order code picks which input component feeds each bus slot, so red, green and blue can be swapped before extraction. A pixel-size field limits how many low bytes of the input word count as pixel data. Configuration comes in on static inputs. Pixels move on valid/ready handshakes, with two register stages between input and output.

Top module: `pix_repack`

## Requirements
- R1: After reset, out_valid and busy are 0 and in_ready is 1.
- R2: cfg_bpp_m1 holds the number of pixel bytes minus one (3 = 32-bit, 2 = 24-bit, 1 = 16-bit). Input bits at or above 8*(cfg_bpp_m1+1) read as zero.
- R3: Input component c (0, 1, 2) uses position cfg_in_pos[5c+4:5c] and mask cfg_in_mask[10c+9:10c]. Bit 9 of its 10-bit field takes the input bit at that position, and bit j takes input bit (position-9+j). Input bits below 0 read as zero, so positions under 9 shift the field left. The result is ANDed with the mask.
- R4: A non-zero scale cfg_scale[4c+3:4c] ORs the masked field with itself shifted right by the scale. A scale of 0 leaves the field as it is.
- R5: cfg_order selects which input component feeds bus slots (red, green, blue): 0 gives (0,1,2), 1 gives (2,1,0), 2 gives (1,0,2), 3 gives (2,0,1). Red is bus bits [29:20].
- R6: Bus slot s (0 = red, 1 = green, 2 = blue) is ANDed with cfg_out_mask[10s+9:10s]. Its bit j then goes to output pin (cfg_out_pos[5s+4:5s]-9+j). Pins outside 0..OUT_W-1 are dropped. Pins that no slot reaches are 0, and slots that overlap are ORed together.
- R7: A pixel accepted on a rising edge (in_valid and in_ready both high) shows on out_pins with out_valid after the next rising edge, provided the output is empty or out_ready is high. While out_valid is high and out_ready is low, out_valid and out_pins hold.
- R8: busy is high exactly when a pixel is held in either stage. in_ready is low only when both stages are full and out_ready is low.
- R9: Configuration is captured only on edges where busy is low. A pixel accepted while busy, and every pixel already in flight, uses the configuration captured last. A change made while busy takes effect once the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_order | input | 2 | Component order code |
| cfg_bpp_m1 | input | 2 | Pixel bytes minus one |
| cfg_in_pos | input | 15 | Input top-bit position per component |
| cfg_in_mask | input | 30 | Input 10-bit mask per component |
| cfg_scale | input | 12 | Replication shift per component |
| cfg_out_pos | input | 15 | Output top-bit position per bus slot |
| cfg_out_mask | input | 30 | Output 10-bit mask per bus slot |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when valid |
| in_pix | input | 32 | Input pixel word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_pins | output | OUT_W (24) | Output bus word |
| busy | output | 1 | A pixel is in the pipeline |

## Verification
The hardest case to reach is a configuration change while a pixel is already in the pipe. Two pixels must be in flight, one of them accepted while the block is already busy, and both must still come out with the old configuration. The stimulus holds out_ready low, sends one pixel, switches the whole configuration, and sends a second pixel. It then releases out_ready and expects both outputs under the old settings. Only after that does it send a third pixel and expect the new settings.

// File: rtl/pix_repack.sv
module pix_repack #(
  parameter int PIX_W = 32,
  parameter int OUT_W = 24,
  parameter int CMP_W = 10,
  parameter int POS_W = 5,
  parameter int SCL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_order,
  input  logic [1:0]           cfg_bpp_m1,
  input  logic [3*POS_W-1:0]   cfg_in_pos,
  input  logic [3*CMP_W-1:0]   cfg_in_mask,
  input  logic [3*SCL_W-1:0]   cfg_scale,
  input  logic [3*POS_W-1:0]   cfg_out_pos,
  input  logic [3*CMP_W-1:0]   cfg_out_mask,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PIX_W-1:0]     in_pix,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [OUT_W-1:0]     out_pins,
  output logic                 busy
);
  localparam int BUS_W = 3 * CMP_W;
  localparam int EXT_W = PIX_W + CMP_W;
  localparam int PLC_W = OUT_W + CMP_W;

  logic [1:0]         h_order, h_bpp;
  logic [3*POS_W-1:0] h_in_pos, h_out_pos;
  logic [BUS_W-1:0]   h_in_mask, h_out_mask;
  logic [3*SCL_W-1:0] h_scale;

  logic [1:0]         e_order, e_bpp;
  logic [3*POS_W-1:0] e_in_pos, e_out_pos;
  logic [BUS_W-1:0]   e_in_mask, e_out_mask;
  logic [3*SCL_W-1:0] e_scale;

  logic               v1, v2, adv1, adv2;
  logic [BUS_W-1:0]   bus_q, bus_d;
  logic [OUT_W-1:0]   pins_d;
  logic [PIX_W-1:0]   keep, pix_m;
  logic [PLC_W-1:0]   placed [3];

  assign busy  = v1 | v2;
  assign adv2  = !v2 || out_ready;
  assign adv1  = !v1 || adv2;
  assign in_ready  = adv1;
  assign out_valid = v2;

  assign e_order    = busy ? h_order    : cfg_order;
  assign e_bpp      = busy ? h_bpp      : cfg_bpp_m1;
  assign e_in_pos   = busy ? h_in_pos   : cfg_in_pos;
  assign e_in_mask  = busy ? h_in_mask  : cfg_in_mask;
  assign e_scale    = busy ? h_scale    : cfg_scale;
  assign e_out_pos  = busy ? h_out_pos  : cfg_out_pos;
  assign e_out_mask = busy ? h_out_mask : cfg_out_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_order    <= '0;
      h_bpp      <= '0;
      h_in_pos   <= '0;
      h_in_mask  <= '0;
      h_scale    <= '0;
      h_out_pos  <= '0;
      h_out_mask <= '0;
    end else if (!busy) begin
      h_order    <= cfg_order;
      h_bpp      <= cfg_bpp_m1;
      h_in_pos   <= cfg_in_pos;
      h_in_mask  <= cfg_in_mask;
      h_scale    <= cfg_scale;
      h_out_pos  <= cfg_out_pos;
      h_out_mask <= cfg_out_mask;
    end
  end

  function automatic logic [1:0] src_of(input logic [1:0] ord, input int slot);
    case (ord)
      2'd0:    return 2'(slot);
      2'd1:    return 2'(2 - slot);
      2'd2:    return (slot == 0) ? 2'd1 : (slot == 1) ? 2'd0 : 2'd2;
      default: return (slot == 0) ? 2'd2 : (slot == 1) ? 2'd0 : 2'd1;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < PIX_W; i++)
      keep[i] = (i / 8) <= int'(e_bpp);
  end
  assign pix_m = in_pix & keep;

  for (genvar s = 0; s < 3; s++) begin : g_slot
    logic [1:0]       src;
    logic [POS_W-1:0] ipos, opos;
    logic [SCL_W-1:0] scl;
    logic [EXT_W-1:0] ext;
    logic [CMP_W-1:0] raw, wide, oval;

    assign src  = src_of(e_order, s);
    assign ipos = e_in_pos[src*POS_W +: POS_W];
    assign scl  = e_scale[src*SCL_W +: SCL_W];
    assign ext  = {pix_m, {(CMP_W-1){1'b0}}} >> ipos;
    assign raw  = ext[CMP_W-1:0] & e_in_mask[src*CMP_W +: CMP_W];
    assign wide = (scl == '0) ? raw : (raw | (raw >> scl));
    assign bus_d[(2-s)*CMP_W +: CMP_W] = wide;

    assign opos = e_out_pos[s*POS_W +: POS_W];
    assign oval = bus_q[(2-s)*CMP_W +: CMP_W] & e_out_mask[s*CMP_W +: CMP_W];
    assign placed[s] = ({{OUT_W{1'b0}}, oval} << opos) >> (CMP_W - 1);
  end

  assign pins_d = placed[0][OUT_W-1:0] | placed[1][OUT_W-1:0] | placed[2][OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1       <= 1'b0;
      v2       <= 1'b0;
      bus_q    <= '0;
      out_pins <= '0;
    end else begin
      if (adv1) begin
        v1 <= in_valid;
        if (in_valid) bus_q <= bus_d;
      end
      if (adv2) begin
        v2 <= v1;
        if (v1) out_pins <= pins_d;
      end
    end
  end
endmodule

module pix_repack_chk #(
  parameter int OUT_W = 24,
  parameter int BUS_W = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_pins,
  input logic             busy,
  input logic [1:0]       h_order,
  input logic [BUS_W-1:0] h_in_mask
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pins));
  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid);
  // R8
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy);
  // R8
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(h_in_mask) && $stable(h_order));
endmodule

bind pix_repack pix_repack_chk #(.OUT_W(OUT_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pins(out_pins),
  .busy(busy), .h_order(h_order), .h_in_mask(h_in_mask)
);

// File: tb/sim_pix_repack.sv
module sim_pix_repack;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  cfg_order = 0, cfg_bpp_m1 = 3;
  logic [14:0] cfg_in_pos = 0, cfg_out_pos = 0;
  logic [29:0] cfg_in_mask = 0, cfg_out_mask = 0;
  logic [11:0] cfg_scale = 0;
  logic        in_valid = 0, out_ready = 1;
  logic [31:0] in_pix = 0;
  logic        in_ready, out_valid, busy;
  logic [23:0] out_pins;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  pix_repack u0 (
    .clk(clk), .rst_n(rst_n), .cfg_order(cfg_order), .cfg_bpp_m1(cfg_bpp_m1),
    .cfg_in_pos(cfg_in_pos), .cfg_in_mask(cfg_in_mask), .cfg_scale(cfg_scale),
    .cfg_out_pos(cfg_out_pos), .cfg_out_mask(cfg_out_mask),
    .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pins(out_pins), .busy(busy)
  );

  localparam int SEL [4][3] = '{'{0,1,2}, '{2,1,0}, '{1,0,2}, '{2,0,1}};

  // {cfg set, order, bytes-1, pixel}
  localparam logic [36:0] VEC [9] = '{
    {1'b0, 2'd0, 2'd3, 32'h00AABBCC},
    {1'b0, 2'd1, 2'd3, 32'h00123456},
    {1'b0, 2'd2, 2'd3, 32'hFF80FF01},
    {1'b0, 2'd3, 2'd3, 32'h5A3C96E1},
    {1'b0, 2'd0, 2'd1, 32'h00FFFFFF},
    {1'b1, 2'd0, 2'd1, 32'hFFFFF81F},
    {1'b1, 2'd0, 2'd1, 32'h000007E0},
    {1'b1, 2'd1, 2'd1, 32'h0000A5C3},
    {1'b0, 2'd0, 2'd2, 32'hEE112233}
  };
  localparam string VTAG [9] = '{"R3", "R5", "R5", "R5", "R2", "R4", "R4", "R5", "R2"};

  function automatic logic [23:0] model(input logic [1:0] ord, input logic [1:0] sz,
      input logic [14:0] ip, input logic [29:0] im, input logic [11:0] sc,
      input logic [14:0] op, input logic [29:0] om, input logic [31:0] w);
    logic [9:0] c, t;
    logic [23:0] r = '0;
    for (int s = 0; s < 3; s++) begin
      int src = SEL[ord][s];
      int p = int'(ip[src*5 +: 5]);
      int sh = int'(sc[src*4 +: 4]);
      int o = int'(op[s*5 +: 5]);
      for (int j = 0; j < 10; j++) begin
        int k = p - 9 + j;
        c[j] = (k >= 0 && k < 8*(int'(sz)+1)) ? (w[k] & im[src*10+j]) : 1'b0;
      end
      t = c;
      if (sh != 0)
        for (int j = 0; j < 10; j++)
          if (j + sh <= 9) c[j] = c[j] | t[j+sh];
      for (int j = 0; j < 10; j++) begin
        int k = o - 9 + j;
        if (k >= 0 && k < 24 && om[s*10+j]) r[k] = r[k] | c[j];
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input bit b, input logic [1:0] ord, input logic [1:0] sz);
    cfg_order = ord;
    cfg_bpp_m1 = sz;
    cfg_out_pos = {5'd7, 5'd15, 5'd23};
    cfg_out_mask = {3{10'h3FC}};
    if (!b) begin
      cfg_in_pos = {5'd7, 5'd15, 5'd23};
      cfg_in_mask = {3{10'h3FC}};
      cfg_scale = '0;
    end else begin
      cfg_in_pos = {5'd4, 5'd10, 5'd15};
      cfg_in_mask = {10'h3E0, 10'h3F0, 10'h3E0};
      cfg_scale = {4'd5, 4'd6, 4'd5};
    end
  endtask

  function automatic logic [23:0] expect_now(input logic [31:0] w);
    return model(cfg_order, cfg_bpp_m1, cfg_in_pos, cfg_in_mask, cfg_scale,
                 cfg_out_pos, cfg_out_mask, w);
  endfunction

  task automatic send(input logic [31:0] w);
    int n = 0;
    in_pix = w;
    in_valid = 1;
    while (!in_ready && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic wait_out(input string tag);
    int n = 0;
    while (!out_valid && n < 50) begin @(negedge clk); n++; end
    if (!out_valid) chk(0, {tag, " timeout"}, 0, 1);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [23:0] e1, e2, e3;
    repeat (3) @(negedge clk);
    // R1
    chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      logic [23:0] e;
      set_cfg(VEC[i][36], VEC[i][35:34], VEC[i][33:32]);
      e = expect_now(VEC[i][31:0]);
      send(VEC[i][31:0]);
      wait_out(VTAG[i]);
      chk(out_pins == e, {VTAG[i], " R6 vector"}, out_pins, e);
      @(negedge clk);
    end

    // R4 scale off vs on: 16-bit red all ones must replicate to 0xFF on the pins
    set_cfg(1, 0, 1);
    send(32'h0000F800);
    wait_out("R4");
    chk(out_pins == 24'hFF0000, "R4 replicate", out_pins, 24'hFF0000);
    @(negedge clk);

    // R6 pins outside masks are zero: clear green output mask
    set_cfg(0, 0, 3);
    cfg_out_mask = {10'h3FC, 10'h000, 10'h3FC};
    send(32'h00FFFFFF);
    wait_out("R6");
    chk(out_pins == 24'hFF00FF, "R6 masked slot", out_pins, 24'hFF00FF);
    @(negedge clk);

    // R7 latency
    set_cfg(0, 0, 3);
    in_pix = 32'h00010203; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 0 && busy == 1, "R7 one edge", {out_valid, busy}, 2'b01);
    @(negedge clk);
    chk(out_valid == 1, "R7 two edges", out_valid, 1);
    chk(out_pins == 24'h010203, "R7 data", out_pins, 24'h010203);
    @(negedge clk);

    // R9 config frozen while busy, R8 full-pipe ready
    set_cfg(0, 0, 3);
    e1 = expect_now(32'h00C0FFEE);
    e2 = expect_now(32'h00123456);
    out_ready = 0;
    send(32'h00C0FFEE);
    @(negedge clk);
    set_cfg(1, 1, 1);
    e3 = expect_now(32'h0000ABCD);
    send(32'h00123456);
    chk(in_ready == 0, "R8 full stall", in_ready, 0);
    chk(busy == 1, "R8 busy", busy, 1);
    repeat (2) @(negedge clk);
    chk(out_valid == 1 && out_pins == e1, "R7 hold", out_pins, e1);
    out_ready = 1;
    @(negedge clk);
    chk(out_pins == e2, "R9 second pixel old cfg", out_pins, e2);
    @(negedge clk);
    chk(busy == 0 && out_valid == 0, "R8 drained", {busy, out_valid}, 0);
    send(32'h0000ABCD);
    wait_out("R9");
    chk(out_pins == e3, "R9 new cfg after idle", out_pins, e3);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule